// File: doc/BRIEF.md
# External-PID Translation Context Selector

This block decides, for every memory access, which process ID, address space and privilege level the access translates under, and then tests that context against a single software-managed translation entry. An access is one of four kinds: an ordinary data access, an instruction fetch, a load through the external context, or a store through the external context. Ordinary accesses use the running process IDs and the machine-state bits. External accesses use one of two context registers instead, one for loads and one for stores, so that privileged code can reach another address space without switching its own.

The block owns the two context registers. A write to either one stores only its supported fields and raises a one-cycle flush request for that context alone. The block reports the outcome of each access (hit, no-match or protection fault) one cycle after the request, together with two syndrome bits that a fault handler reads.

Top module: `ext_ctx_sel`

## Requirements
- R1: A context register keeps only bits 7:0 (process ID), bit 30 (address-space flag) and bit 31 (user-privilege flag) of a written value; all other bits, including 29 and 21:16, read back as zero. Both registers reset to zero.
- R2: A write with `cfg_wr_sel`=0 updates the load context and raises `flush_load` for exactly the following cycle; `cfg_wr_sel`=1 does the same for the store context and `flush_store`. A write never changes the other register nor raises the other flush.
- R3: An ordinary data access (kind 0) matches the entry when the entry's ID equals `pid0`, or equals `pid1` with `pid1` nonzero, or equals `pid2` with `pid2` nonzero.
- R4: An external access (kind 2 uses the load context, kind 3 the store context) matches only when the entry's ID equals that register's process ID; `pid0`, `pid1` and `pid2` play no part.
- R5: An entry ID of zero matches every access kind, as a global mapping.
- R6: Privilege for the permission check is the selected register's bit 31 on external accesses and `ms_pr` otherwise; user mode reads `ent_perm` bits 5:3 (execute, write, read), supervisor mode bits 2:0 in the same order.
- R7: For data accesses the entry's `ent_ts` must equal the effective address space (register bit 30 on external accesses, `ms_dr` for kind 0); a mismatch gives no-match, never a protection fault. An invalid entry gives no-match.
- R8: An instruction fetch (kind 1) never uses a context register: it matches against the process IDs, compares `ent_ts` with `ms_ir`, uses `ms_pr`, and needs execute permission; `req_write` is ignored for it.
- R9: Kind 0 needs write permission when `req_write`=1 and read permission otherwise; kind 2 always needs read and kind 3 always write, whatever `req_write` is. A matched entry lacking the permission gives a protection fault.
- R10: On a no-match or protection fault of a data access (kinds 0, 2, 3), `rsp_syn_store` is 1 for a write and `rsp_syn_ext` is 1 for kinds 2 and 3; on a hit, and on any fetch, both are 0.
- R11: The result appears on the cycle after a request with `rsp_valid`=1 and `rsp_code` 2'b01 hit, 2'b00 no-match, 2'b10 protection fault; with no request, `rsp_valid`, `rsp_code` and the syndrome bits are all 0. An external access uses the register value held before a write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Context register write strobe |
| cfg_wr_sel | input | 1 | 0 selects the load context, 1 the store context |
| cfg_wr_data | input | 32 | Value to write |
| load_ctx | output | 32 | Load context register contents |
| store_ctx | output | 32 | Store context register contents |
| flush_load | output | 1 | One-cycle flush request for load-context translations |
| flush_store | output | 1 | One-cycle flush request for store-context translations |
| pid0 | input | 8 | Primary process ID |
| pid1 | input | 8 | Second process ID, 0 means unused |
| pid2 | input | 8 | Third process ID, 0 means unused |
| ms_pr | input | 1 | Machine state: user (problem) mode |
| ms_dr | input | 1 | Machine state: data address space |
| ms_ir | input | 1 | Machine state: instruction address space |
| req_valid | input | 1 | Access request strobe |
| req_kind | input | 2 | 0 data, 1 fetch, 2 external load, 3 external store |
| req_write | input | 1 | Write flag for kind 0 |
| ent_valid | input | 1 | Translation entry valid |
| ent_tid | input | 8 | Entry process ID, 0 = global |
| ent_ts | input | 1 | Entry address space |
| ent_perm | input | 6 | {UX,UW,UR,SX,SW,SR} permission bits |
| rsp_valid | output | 1 | Result valid |
| rsp_code | output | 2 | 01 hit, 00 no-match, 10 protection fault |
| rsp_syn_store | output | 1 | Syndrome: faulting access was a write |
| rsp_syn_ext | output | 1 | Syndrome: faulting access used an external context |

## Verification
On every cycle the assertions check that a flush pulse follows only a write to its own register and never pairs with the other, that a result follows each request and only a request, that a hit carries a clean syndrome, that the external syndrome bit traces back to an external request, and that a fetch never takes the external context. Whether the right ID, address space and privilege were chosen, and whether the permission and match outcomes are right, only the bench's sweeps over every kind, machine-state combination, entry ID, address space and permission pattern can show, against two different sets of context registers and process IDs. Register masking and flush isolation are shown by targeted writes.

// File: rtl/ext_ctx_pkg.sv
package ext_ctx_pkg;
  typedef enum logic [1:0] {
    KIND_DATA   = 2'd0,
    KIND_FETCH  = 2'd1,
    KIND_EXT_LD = 2'd2,
    KIND_EXT_ST = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    RES_MISS = 2'b00,
    RES_HIT  = 2'b01,
    RES_PROT = 2'b10
  } acc_res_e;

  localparam int CTX_AS_BIT = 30;
  localparam int CTX_PR_BIT = 31;

  // permission vector layout: supervisor triple low, user triple high
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;
  localparam int PERM_USER_BASE = 3;
endpackage

// File: rtl/ext_ctx_regs.sv
module ext_ctx_regs #(
  parameter int REG_W = 32,
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ld_q,
  output logic [REG_W-1:0] st_q,
  output logic             flush_ld,
  output logic             flush_st
);
  import ext_ctx_pkg::*;

  localparam logic [REG_W-1:0] KEEP_MASK =
    (REG_W'(1) << CTX_PR_BIT) | (REG_W'(1) << CTX_AS_BIT) | ((REG_W'(1) << PID_W) - REG_W'(1));

  logic [REG_W-1:0] ld_d, st_d;
  logic             fl_ld_d, fl_st_d;
  logic             ld_we, st_we;

  always_comb begin
    ld_we   = wr_en && !wr_sel;
    st_we   = wr_en &&  wr_sel;
    ld_d    = ld_we ? (wr_data & KEEP_MASK) : ld_q;
    st_d    = st_we ? (wr_data & KEEP_MASK) : st_q;
    fl_ld_d = ld_we;
    fl_st_d = st_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q     <= '0;
      st_q     <= '0;
      flush_ld <= 1'b0;
      flush_st <= 1'b0;
    end else begin
      ld_q     <= ld_d;
      st_q     <= st_d;
      flush_ld <= fl_ld_d;
      flush_st <= fl_st_d;
    end
  end

  p_flush_ld_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ld |-> $past(wr_en && !wr_sel));
  p_flush_st_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flush_st |-> $past(wr_en && wr_sel));
  p_flush_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_ld, flush_st}));
  p_ld_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> $stable(ld_q));
endmodule

// File: rtl/ext_ctx_pick.sv
module ext_ctx_pick #(
  parameter int PID_W = 8
) (
  input  logic [1:0]       kind,
  input  logic             req_write,
  input  logic             ms_pr,
  input  logic             ms_dr,
  input  logic             ms_ir,
  input  logic [PID_W-1:0] ld_pid,
  input  logic             ld_as,
  input  logic             ld_pr,
  input  logic [PID_W-1:0] st_pid,
  input  logic             st_as,
  input  logic             st_pr,
  output logic             use_ext,
  output logic [PID_W-1:0] eff_pid,
  output logic             eff_as,
  output logic             eff_pr,
  output logic             is_fetch,
  output logic             is_write
);
  import ext_ctx_pkg::*;

  always_comb begin
    use_ext  = 1'b0;
    eff_pid  = '0;
    eff_as   = ms_dr;
    eff_pr   = ms_pr;
    is_fetch = 1'b0;
    is_write = 1'b0;
    unique case (acc_kind_e'(kind))
      KIND_DATA: begin
        is_write = req_write;
      end
      KIND_FETCH: begin
        is_fetch = 1'b1;
        eff_as   = ms_ir;
      end
      KIND_EXT_LD: begin
        use_ext = 1'b1;
        eff_pid = ld_pid;
        eff_as  = ld_as;
        eff_pr  = ld_pr;
      end
      KIND_EXT_ST: begin
        use_ext  = 1'b1;
        eff_pid  = st_pid;
        eff_as   = st_as;
        eff_pr   = st_pr;
        is_write = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ext_ctx_entry_chk.sv
module ext_ctx_entry_chk #(
  parameter int PID_W   = 8,
  parameter int NUM_PID = 3
) (
  input  logic [NUM_PID-1:0][PID_W-1:0] pid_list,
  input  logic                          use_ext,
  input  logic [PID_W-1:0]              eff_pid,
  input  logic                          eff_as,
  input  logic                          eff_pr,
  input  logic                          is_fetch,
  input  logic                          is_write,
  input  logic                          ent_valid,
  input  logic [PID_W-1:0]              ent_tid,
  input  logic                          ent_ts,
  input  logic [5:0]                    ent_perm,
  output logic [1:0]                    res,
  output logic                          syn_store,
  output logic                          syn_ext
);
  import ext_ctx_pkg::*;

  logic [NUM_PID-1:0] pid_hit;
  logic               id_match, as_match, perm_ok;
  logic [2:0]         perm_set;

  // slot 0 is always consulted; the others only when programmed nonzero
  for (genvar i = 0; i < NUM_PID; i++) begin : g_pid
    if (i == 0) begin : g_first
      assign pid_hit[i] = (ent_tid == pid_list[i]);
    end else begin : g_rest
      assign pid_hit[i] = (pid_list[i] != '0) && (ent_tid == pid_list[i]);
    end
  end

  always_comb begin
    if (ent_tid == '0)
      id_match = 1'b1;
    else if (use_ext)
      id_match = (ent_tid == eff_pid);
    else
      id_match = |pid_hit;

    as_match = (ent_ts == eff_as);
    perm_set = eff_pr ? ent_perm[PERM_USER_BASE +: 3] : ent_perm[2:0];

    if (is_fetch)
      perm_ok = perm_set[PERM_EX];
    else if (is_write)
      perm_ok = perm_set[PERM_WR];
    else
      perm_ok = perm_set[PERM_RD];

    if (!ent_valid || !id_match || !as_match)
      res = RES_MISS;
    else if (!perm_ok)
      res = RES_PROT;
    else
      res = RES_HIT;

    syn_store = (res != RES_HIT) && !is_fetch && is_write;
    syn_ext   = (res != RES_HIT) && !is_fetch && use_ext;
  end
endmodule

// File: rtl/ext_ctx_sel.sv
module ext_ctx_sel #(
  parameter int REG_W = 32,
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic             cfg_wr_sel,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] load_ctx,
  output logic [REG_W-1:0] store_ctx,
  output logic             flush_load,
  output logic             flush_store,
  input  logic [PID_W-1:0] pid0,
  input  logic [PID_W-1:0] pid1,
  input  logic [PID_W-1:0] pid2,
  input  logic             ms_pr,
  input  logic             ms_dr,
  input  logic             ms_ir,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             req_write,
  input  logic             ent_valid,
  input  logic [PID_W-1:0] ent_tid,
  input  logic             ent_ts,
  input  logic [5:0]       ent_perm,
  output logic             rsp_valid,
  output logic [1:0]       rsp_code,
  output logic             rsp_syn_store,
  output logic             rsp_syn_ext
);
  import ext_ctx_pkg::*;

  localparam int NUM_PID = 3;

  logic [NUM_PID-1:0][PID_W-1:0] pid_list;
  logic             use_ext, eff_as, eff_pr, is_fetch, is_write;
  logic [PID_W-1:0] eff_pid;
  logic [1:0]       res_c;
  logic             syn_st_c, syn_ext_c;
  logic             vld_d, st_d, ex_d;
  logic [1:0]       code_d;

  assign pid_list = {pid2, pid1, pid0};

  ext_ctx_regs #(.REG_W(REG_W), .PID_W(PID_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_sel   (cfg_wr_sel),
    .wr_data  (cfg_wr_data),
    .ld_q     (load_ctx),
    .st_q     (store_ctx),
    .flush_ld (flush_load),
    .flush_st (flush_store)
  );

  ext_ctx_pick #(.PID_W(PID_W)) u_pick (
    .kind      (req_kind),
    .req_write (req_write),
    .ms_pr     (ms_pr),
    .ms_dr     (ms_dr),
    .ms_ir     (ms_ir),
    .ld_pid    (load_ctx[PID_W-1:0]),
    .ld_as     (load_ctx[CTX_AS_BIT]),
    .ld_pr     (load_ctx[CTX_PR_BIT]),
    .st_pid    (store_ctx[PID_W-1:0]),
    .st_as     (store_ctx[CTX_AS_BIT]),
    .st_pr     (store_ctx[CTX_PR_BIT]),
    .use_ext   (use_ext),
    .eff_pid   (eff_pid),
    .eff_as    (eff_as),
    .eff_pr    (eff_pr),
    .is_fetch  (is_fetch),
    .is_write  (is_write)
  );

  ext_ctx_entry_chk #(.PID_W(PID_W), .NUM_PID(NUM_PID)) u_chk (
    .pid_list  (pid_list),
    .use_ext   (use_ext),
    .eff_pid   (eff_pid),
    .eff_as    (eff_as),
    .eff_pr    (eff_pr),
    .is_fetch  (is_fetch),
    .is_write  (is_write),
    .ent_valid (ent_valid),
    .ent_tid   (ent_tid),
    .ent_ts    (ent_ts),
    .ent_perm  (ent_perm),
    .res       (res_c),
    .syn_store (syn_st_c),
    .syn_ext   (syn_ext_c)
  );

  always_comb begin
    vld_d  = req_valid;
    code_d = req_valid ? res_c     : RES_MISS;
    st_d   = req_valid ? syn_st_c  : 1'b0;
    ex_d   = req_valid ? syn_ext_c : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_code      <= RES_MISS;
      rsp_syn_store <= 1'b0;
      rsp_syn_ext   <= 1'b0;
    end else begin
      rsp_valid     <= vld_d;
      rsp_code      <= code_d;
      rsp_syn_store <= st_d;
      rsp_syn_ext   <= ex_d;
    end
  end

  p_rsp_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_code == 2'b00 && !rsp_syn_store && !rsp_syn_ext));
  p_hit_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'b01) |-> (!rsp_syn_store && !rsp_syn_ext));
  p_ext_syn_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_syn_ext |-> $past(req_kind[1] && req_valid));
  p_fetch_local_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1) |-> !use_ext);
  p_code_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_code != 2'b11);
endmodule

// File: tb/ext_ctx_sel_test.sv
module ext_ctx_sel_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en, cfg_wr_sel;
  logic [31:0] cfg_wr_data;
  logic [31:0] load_ctx, store_ctx;
  logic        flush_load, flush_store;
  logic [7:0]  pid0, pid1, pid2;
  logic        ms_pr, ms_dr, ms_ir;
  logic        req_valid, req_write;
  logic [1:0]  req_kind;
  logic        ent_valid, ent_ts;
  logic [7:0]  ent_tid;
  logic [5:0]  ent_perm;
  logic        rsp_valid, rsp_syn_store, rsp_syn_ext;
  logic [1:0]  rsp_code;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  ext_ctx_sel uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .load_ctx(load_ctx), .store_ctx(store_ctx),
    .flush_load(flush_load), .flush_store(flush_store),
    .pid0(pid0), .pid1(pid1), .pid2(pid2),
    .ms_pr(ms_pr), .ms_dr(ms_dr), .ms_ir(ms_ir),
    .req_valid(req_valid), .req_kind(req_kind), .req_write(req_write),
    .ent_valid(ent_valid), .ent_tid(ent_tid), .ent_ts(ent_ts), .ent_perm(ent_perm),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_syn_store(rsp_syn_store), .rsp_syn_ext(rsp_syn_ext)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {valid, code, store, ext} from the requirements
  function automatic logic [4:0] model(
      input logic [1:0] kind, input logic wr, input logic pr, input logic dr,
      input logic ir, input logic [31:0] lctx, input logic [31:0] sctx,
      input logic [7:0] p0, input logic [7:0] p1, input logic [7:0] p2,
      input logic ev, input logic [7:0] tid, input logic ts, input logic [5:0] perm);
    logic ext, fetch, w, epr, eas, idm, ok;
    logic [31:0] c;
    logic [1:0] code;
    logic [2:0] set;
    ext   = kind[1];
    fetch = (kind == 2'd1);
    c     = (kind == 2'd3) ? sctx : lctx;
    w     = (kind == 2'd0) ? wr : (kind == 2'd3);
    epr   = ext ? c[31] : pr;
    eas   = ext ? c[30] : (fetch ? ir : dr);
    if (tid == 8'd0) idm = 1'b1;
    else if (ext) idm = (tid == c[7:0]);
    else idm = (tid == p0) || (p1 != 0 && tid == p1) || (p2 != 0 && tid == p2);
    set = epr ? perm[5:3] : perm[2:0];
    ok  = fetch ? set[2] : (w ? set[1] : set[0]);
    if (!ev || !idm || ts != eas) code = 2'b00;
    else if (!ok) code = 2'b10;
    else code = 2'b01;
    model = {1'b1, code, (code != 2'b01) && !fetch && w, (code != 2'b01) && !fetch && ext};
  endfunction

  task automatic wr_ctx(input logic sel, input logic [31:0] v);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic sweep(input string tag);
    logic [7:0] tids [6];
    logic [4:0] exp_q;
    logic       have;
    tids[0] = 8'h00; tids[1] = 8'h11; tids[2] = 8'h22;
    tids[3] = 8'h33; tids[4] = 8'h44; tids[5] = 8'h55;
    have = 1'b0; exp_q = '0;
    for (int k = 0; k < 4; k++)
      for (int w = 0; w < 2; w++)
        for (int ms = 0; ms < 8; ms++)
          for (int t = 0; t < 6; t++)
            for (int ts = 0; ts < 2; ts++)
              for (int pm = 0; pm < 64; pm++) begin
                req_valid = 1'b1; req_kind = 2'(k); req_write = 1'(w);
                ms_pr = ms[0]; ms_dr = ms[1]; ms_ir = ms[2];
                ent_valid = !(pm == 63 && t == 0 && ts == 0 && ms == 0);
                ent_tid = tids[t]; ent_ts = 1'(ts); ent_perm = 6'(pm);
                @(negedge clk);
                // R3 R4 R5 R6 R7 R8 R9 R10 R11: previous cycle's request resolved now
                chk({"R3/R4/R5 R6 R7 R8 R9 R10 R11 ", tag}, {27'd0, rsp_valid, rsp_code, rsp_syn_store, rsp_syn_ext},
                    {27'd0, model(2'(k), 1'(w), ms[0], ms[1], ms[2], load_ctx, store_ctx,
                                  pid0, pid1, pid2, ent_valid, tids[t], 1'(ts), 6'(pm))});
                have = 1'b1;
              end
    req_valid = 1'b0;
    @(negedge clk);
    chk({"R11 idle ", tag}, {28'd0, rsp_valid, rsp_code, rsp_syn_store}, 32'd0);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_wr_en = 0; cfg_wr_sel = 0; cfg_wr_data = 0;
    pid0 = 8'h11; pid1 = 8'h22; pid2 = 8'h00;
    ms_pr = 0; ms_dr = 0; ms_ir = 0;
    req_valid = 0; req_kind = 0; req_write = 0;
    ent_valid = 0; ent_tid = 0; ent_ts = 0; ent_perm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset load_ctx", load_ctx, 32'd0);
    chk("R1 reset store_ctx", store_ctx, 32'd0);
    chk("R11 reset rsp", {29'd0, rsp_valid, rsp_code}, 32'd0);
    chk("R2 reset flush", {30'd0, flush_load, flush_store}, 32'd0);

    // R1 masking, R2 flush isolation
    wr_ctx(1'b0, 32'hFFFF_FFFF);
    chk("R1 mask all-ones", load_ctx, 32'hC000_00FF);
    chk("R2 flush_load pulse", {30'd0, flush_load, flush_store}, 32'd2);
    @(negedge clk);
    chk("R2 flush_load one cycle", {30'd0, flush_load, flush_store}, 32'd0);
    wr_ctx(1'b1, 32'h2A3F_00A5);
    chk("R1 mask guest/partition", store_ctx, 32'h0000_00A5);
    chk("R2 store write leaves load", load_ctx, 32'hC000_00FF);
    chk("R2 flush_store pulse", {30'd0, flush_load, flush_store}, 32'd1);
    @(negedge clk);
    chk("R2 flush_store one cycle", {30'd0, flush_load, flush_store}, 32'd0);

    // R11: same-cycle write and external load sees old context (tid 0x44 vs 0xFF)
    cfg_wr_en = 1'b1; cfg_wr_sel = 1'b0; cfg_wr_data = 32'h4000_0044;
    req_valid = 1'b1; req_kind = 2'd2; req_write = 1'b0;
    ent_valid = 1'b1; ent_tid = 8'h44; ent_ts = 1'b1; ent_perm = 6'b000111;
    @(negedge clk);
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    chk("R11 old context used", {30'd0, rsp_code}, 32'd0);

    // configuration A
    wr_ctx(1'b0, 32'h4000_0044);
    wr_ctx(1'b1, 32'h8000_0055);
    sweep("cfgA");

    // configuration B: flags swapped, pid2 enabled
    pid2 = 8'h33;
    wr_ctx(1'b0, 32'h8000_0044);
    wr_ctx(1'b1, 32'h4000_0055);
    sweep("cfgB");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule